// File: doc/BRIEF.md
# Variable-Length Bitstream Packer

This block gathers variable-length code fragments into one wide shift register. A typical pair is an entropy codeword followed by its amplitude bits. Each accepted fragment moves the register contents left by the fragment length and drops the new bits into the vacated low end. A running bit count tracks how much of the register holds data. The result is a single contiguous bitstream. The oldest bit sits highest and the newest bit sits lowest.

When the host asks for the data, the block first moves the stored bits up so that they start at the register's most significant bit. It then hands them out as words of `WORD_W` bits, top bits first, one word per cycle. The last word is filled with ones if it is only partly used. The host learns how many words to expect from `word_cnt`, which is the bit count divided by the word width, rounded up. The word stream is therefore complete even when the trailing data bits are all zero.

If a fragment would push the register past its capacity, the block discards it and raises a sticky overflow flag. After the last word has gone out, the register, the bit count and the flag are all cleared, ready for the next block of data.

Top module: `vlc_packer`

## Requirements
- R1: After reset, `word_vld` is 0, `word_cnt` is 0 and `ovf` is 0.
- R2: A fragment with `frag_vld` high and `frag_len` L (1 to `MAX_LEN`) is appended after all earlier accepted bits. Only bits L-1..0 of `frag_val` are used, and bit L-1 goes out first.
- R3: Two fragments are concatenated in the order they arrive. For example, a 3-bit code 100 followed by a 3-bit amplitude 110 gives a first output word of 0x9BFFFFFF (100110 followed by 26 padding ones).
- R4: One cycle after a fragment is accepted, `word_cnt` equals ceil(bits held / `WORD_W`).
- R5: When `flush` is sampled high while bits are held, the first word appears with `word_vld` one cycle later. The remaining words follow on consecutive cycles. Exactly `word_cnt` words are produced, and this holds even when the data bits are all zero.
- R6: If the bit count is not a multiple of `WORD_W`, the unused low bits of the final word are ones. If it is a multiple, no padding is added.
- R7: A fragment that would make the bit count exceed `ACC_W` is dropped and sets `ovf`. A fragment that fills the register exactly is accepted and does not set `ovf`.
- R8: In the cycle after the last word, the bit count, `word_cnt` and `ovf` are all 0.
- R9: Fragments and `flush` presented while words are being drained are ignored. A fragment presented in the same cycle as `flush` is ignored. A fragment with length 0 or greater than `MAX_LEN` is ignored.
- R10: A `flush` when no bits are held produces no words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frag_vld | input | 1 | Fragment strobe |
| frag_val | input | MAX_LEN (27) | Fragment bits, right-aligned |
| frag_len | input | clog2(MAX_LEN+1) (5) | Fragment length in bits |
| flush | input | 1 | Start readout of the held bits |
| word_vld | output | 1 | Output word strobe |
| word_data | output | WORD_W (32) | Output word, earliest bit at the MSB |
| word_cnt | output | clog2(ACC_W+1) (11) | Words the held bits will produce |
| ovf | output | 1 | Sticky: a fragment was dropped |

## Verification
The bench builds the packer with `ACC_W` = 128 and keeps the defaults `WORD_W` = 32 and `MAX_LEN` = 27. The shallow register means that a handful of 27-bit fragments reach the capacity edge. This puts the exact-fill case and the dropped-fragment case within a few cycles, and it lets random blocks that overrun the register be checked quickly. The 4-word maximum drain also makes it practical to inject inputs during a drain and then confirm that they had no effect.

// File: rtl/vlc_packer.sv
module vlc_packer #(
  parameter int ACC_W   = 1024,
  parameter int WORD_W  = 32,
  parameter int MAX_LEN = 27,
  localparam int CNT_W  = $clog2(ACC_W + 1),
  localparam int LEN_W  = $clog2(MAX_LEN + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frag_vld,
  input  logic [MAX_LEN-1:0] frag_val,
  input  logic [LEN_W-1:0]   frag_len,
  input  logic               flush,
  output logic               word_vld,
  output logic [WORD_W-1:0]  word_data,
  output logic [CNT_W-1:0]   word_cnt,
  output logic               ovf
);

  logic [ACC_W-1:0] acc;
  logic [CNT_W-1:0] fill, rem;
  logic             draining;

  wire              len_ok   = (frag_len != '0) && (int'(frag_len) <= MAX_LEN);
  wire [CNT_W:0]    fill_sum = {1'b0, fill} + (CNT_W+1)'(frag_len);
  wire              fits     = fill_sum <= (CNT_W+1)'(ACC_W);

  wire [MAX_LEN-1:0] val_mask = ~({MAX_LEN{1'b1}} << frag_len);
  wire [ACC_W-1:0]   acc_app  = (acc << frag_len) | ACC_W'(frag_val & val_mask);
  wire [CNT_W-1:0]   align_sh = CNT_W'(ACC_W) - fill;
  wire [WORD_W-1:0]  pad      = {WORD_W{1'b1}} >> rem;
  wire [CNT_W:0]     cnt_ext  = ({1'b0, fill} + (CNT_W+1)'(WORD_W - 1)) / (CNT_W+1)'(WORD_W);

  assign word_cnt = cnt_ext[CNT_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc       <= '0;
      fill      <= '0;
      rem       <= '0;
      draining  <= 1'b0;
      word_vld  <= 1'b0;
      word_data <= '0;
      ovf       <= 1'b0;
    end else begin
      word_vld <= 1'b0;
      if (draining) begin
        word_vld  <= 1'b1;
        word_data <= acc[ACC_W-1 -: WORD_W] | pad;
        if (rem <= CNT_W'(WORD_W)) begin
          draining <= 1'b0;
          rem      <= '0;
          fill     <= '0;
          ovf      <= 1'b0;
          acc      <= '0;
        end else begin
          rem <= rem - CNT_W'(WORD_W);
          acc <= acc << WORD_W;
        end
      end else if (flush) begin
        if (fill != '0) begin
          acc      <= acc << align_sh;
          rem      <= fill;
          draining <= 1'b1;
        end
      end else if (frag_vld && len_ok) begin
        if (fits) begin
          acc  <= acc_app;
          fill <= fill_sum[CNT_W-1:0];
        end else begin
          ovf <= 1'b1;
        end
      end
    end
  end

  // R7
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CNT_W'(ACC_W));

  // R7
  ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf) |-> $past(frag_vld) && !$past(draining));

  // R5
  word_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld |-> $past(draining));

  // R9
  drain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (draining && $past(draining)) |-> $stable(fill));

  // R8
  drain_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(draining) |-> (fill == '0) && !ovf);

endmodule

// File: tb/vlc_packer_bench.sv
module vlc_packer_bench;
  localparam int ACC_W = 128, WORD_W = 32, MAX_LEN = 27;
  localparam int CNT_W = $clog2(ACC_W + 1), LEN_W = $clog2(MAX_LEN + 1);

  logic clk = 0, rst_n = 0;
  logic frag_vld = 0, flush = 0;
  logic [MAX_LEN-1:0] frag_val = '0;
  logic [LEN_W-1:0]   frag_len = '0;
  logic word_vld, ovf;
  logic [WORD_W-1:0] word_data;
  logic [CNT_W-1:0]  word_cnt;

  vlc_packer #(.ACC_W(ACC_W), .WORD_W(WORD_W), .MAX_LEN(MAX_LEN)) u_vlc_packer (
    .clk(clk), .rst_n(rst_n), .frag_vld(frag_vld), .frag_val(frag_val),
    .frag_len(frag_len), .flush(flush), .word_vld(word_vld),
    .word_data(word_data), .word_cnt(word_cnt), .ovf(ovf));

  always #4 clk = ~clk;

  int tests = 0, fails = 0;
  bit done = 0;
  bit mdl[$];
  bit ovf_m = 0;
  logic [WORD_W-1:0] exp_q[$];
  logic [WORD_W-1:0] last_word = '0;
  logic [WORD_W-1:0] first_word = '0;
  int seen = 0;

  task automatic chk(bit ok, string tag, longint act, longint expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (word_vld) begin
      if (seen == 0) first_word = word_data;
      seen++;
      last_word = word_data;
      if (exp_q.size() == 0) chk(0, "R5/R9 unexpected word", word_data, 0);
      else begin
        logic [WORD_W-1:0] e;
        e = exp_q.pop_front();
        chk(word_data == e, "R2/R5/R6 word", word_data, e);
      end
    end
  end

  task automatic send(logic [MAX_LEN-1:0] v, int len);
    @(negedge clk);
    frag_vld = 1; frag_val = v; frag_len = LEN_W'(len);
    if (len >= 1 && len <= MAX_LEN) begin
      if (mdl.size() + len <= ACC_W)
        for (int i = len - 1; i >= 0; i--) mdl.push_back(v[i]);
      else ovf_m = 1;
    end
    @(negedge clk);
    frag_vld = 0;
    chk(int'(word_cnt) == (mdl.size() + WORD_W - 1) / WORD_W, "R4 word_cnt",
        word_cnt, (mdl.size() + WORD_W - 1) / WORD_W);
    chk(ovf == ovf_m, "R7 ovf", ovf, ovf_m);
  endtask

  task automatic flush_blk(bit same_frag, bit noise);
    int n;
    n = (mdl.size() + WORD_W - 1) / WORD_W;
    for (int w = 0; w < n; w++) begin
      logic [WORD_W-1:0] e;
      for (int b = 0; b < WORD_W; b++) begin
        int idx;
        idx = w * WORD_W + b;
        e[WORD_W-1-b] = (idx < mdl.size()) ? mdl[idx] : 1'b1;
      end
      exp_q.push_back(e);
    end
    mdl.delete();
    ovf_m = 0;
    seen = 0;
    @(negedge clk);
    flush = 1;
    if (same_frag) begin frag_vld = 1; frag_val = 27'h5; frag_len = 5'd3; end
    @(negedge clk);
    flush = 0; frag_vld = 0;
    if (noise) begin
      frag_vld = 1; flush = 1; frag_val = 27'h7FFFFFF; frag_len = 5'd27;
      @(negedge clk);
      frag_vld = 0; flush = 0;
    end
    repeat (n + 3) @(negedge clk);
    chk(seen == n, "R5 word count", seen, n);
    chk(exp_q.size() == 0, "R5 words outstanding", exp_q.size(), 0);
    chk(word_cnt == 0, "R8/R9 word_cnt after drain", word_cnt, 0);
    chk(ovf == 0, "R8 ovf after drain", ovf, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(word_vld == 0, "R1 word_vld", word_vld, 0);
    chk(word_cnt == 0, "R1 word_cnt", word_cnt, 0);
    chk(ovf == 0, "R1 ovf", ovf, 0);
    rst_n = 1;

    // R3: codeword then amplitude
    send(27'h4, 3);
    send(27'h6, 3);
    flush_blk(0, 0);
    chk(last_word == 32'h9BFFFFFF, "R3 concatenation", last_word, 32'h9BFFFFFF);

    // R10: empty flush
    flush_blk(0, 0);
    chk(seen == 0, "R10 no words", seen, 0);

    // R2: upper bits ignored, len 0 and len 28 ignored (R9)
    send(27'h7FFFFF5, 4);
    send(27'h1234, 0);
    send(27'h7FFFFFF, 28);
    send(27'h1, 1);
    flush_blk(0, 0);
    chk(last_word == 32'h5FFFFFFF, "R2 masked value", last_word, 32'h5FFFFFFF);

    // R5: all-zero data still emits words; R6 no padding on full word
    send(27'h0, 16);
    send(27'h0, 16);
    send(27'h0, 10);
    flush_blk(0, 0);
    chk(first_word == 32'h0, "R6 full word unpadded", first_word, 0);
    chk(last_word == 32'h003FFFFF, "R6 zero data padded", last_word, 32'h003FFFFF);

    // R7: exact fill accepted, then overflow dropped
    for (int i = 0; i < 4; i++) send(27'h2AAAAAA + 27'(i), 27);
    send(27'hABCDE, 20);
    chk(ovf == 0, "R7 exact fill no ovf", ovf, 0);
    send(27'h1, 1);
    chk(ovf == 1, "R7 overflow flagged", ovf, 1);
    flush_blk(0, 0);

    // R9: fragment with flush, and inputs during drain
    send(27'h3FF, 10);
    send(27'h155, 9);
    send(27'h7000001, 27);
    flush_blk(1, 1);

    // random blocks, some overrunning
    for (int blk = 0; blk < 20; blk++) begin
      int nf;
      nf = 1 + int'($urandom_range(0, 7));
      for (int f = 0; f < nf; f++)
        send(27'($urandom), 1 + int'($urandom_range(0, MAX_LEN - 1)));
      flush_blk(blk % 3 == 0, blk % 4 == 1);
    end

    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule